// File: doc/BRIEF.md
# Counting Bloom Snoop Filter

This block sits at the edge of one bus segment and answers one question for each snoop: could this cache line be on the far side of the boundary? It keeps two tables of saturating counters. Each table is indexed by its own hash of the line address. Inserting a line raises the selected counter in each table, and removing the line lowers them. A lookup reports "may be present" only when both selected counters are non-zero. Because the counters can go down again, lines leave the filter as well as enter it. A line that has been inserted and not removed is always reported. A line that was never inserted can still be reported when it collides with other lines.

Two instances cover one segment. The first tracks lines homed in the segment that have been sent outside it. The second tracks lines currently held inside the segment. Updates and lookups each have their own valid/ready channel. A lookup answers one cycle after it is accepted. A synchronous clear sweeps the tables to zero. Reset starts the same sweep, so the counter storage needs no reset and can map onto RAM.

Top module: `snoop_line_filter`

## Requirements
- R1: After reset, `upd_ready` and `qry_ready` stay low for exactly 2^IDX_W (1024) cycles. After that every lookup misses and `underflow_err` is 0.
- R2: Table A is indexed by `addr[9:0] ^ addr[19:10]`. Table B is indexed by `addr[9:0] ^ addr[29:20]`.
- R3: An accepted update with `upd_del`=0 adds one to the selected counter in both tables. A lookup of any inserted line that has not been removed reports 1.
- R4: A lookup reports 1 only if the counter it selects in table A and the counter it selects in table B are both non-zero. A line whose two indices were each raised by other lines therefore reports 1.
- R5: An accepted update with `upd_del`=1 subtracts one from each selected counter that is non-zero. A line inserted twice and removed once still hits. After the second removal it misses.
- R6: Counters stop at 1023 and do not wrap. After 1025 inserts of one line, 1022 removes leave it present and the 1023rd remove makes it miss. No error is raised during this.
- R7: A remove whose selected counter is zero leaves that counter at zero but still decrements the counter in the other table. It sets `underflow_err`, which stays 1 until reset.
- R8: `hit_valid` pulses in the cycle after a lookup is accepted and at no other time. If an update to the same indices is accepted in the same cycle, the lookup result includes that update.
- R9: A `clr_req` pulse while ready is high drops both readies from the next cycle for exactly 1024 cycles. Afterwards all lines miss, including a line inserted in the same cycle as the request. `underflow_err` is left unchanged.
- R10: The update and lookup channels accept independently in the same cycle for unrelated addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clear sweep |
| clr_req | input | 1 | Request to zero all counters |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update channel ready (low while clearing) |
| upd_del | input | 1 | 0 = insert line, 1 = remove line |
| upd_addr | input | ADDR_W (30) | Line address for the update |
| qry_valid | input | 1 | Lookup request valid |
| qry_ready | output | 1 | Lookup channel ready (low while clearing) |
| qry_addr | input | ADDR_W (30) | Line address to look up |
| hit_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| hit_out | output | 1 | 1 = line may be present |
| underflow_err | output | 1 | Sticky flag: a remove found a zero counter |

## Verification
An update and a lookup can be accepted in the same clock edge. When both target the same counters, the answer must already include the update. The bench provokes this by driving an insert of a line not yet present together with a lookup of that line, which must answer 1. It also drives the removal of a line's last copy together with its lookup, which must answer 0. Both verdicts are compared with an arithmetic model of the two tables in the bench. The same cycle overlap is also provoked between a clear request and an insert, and the inserted line must be gone once the sweep ends.

// File: rtl/slf_pkg.sv
package slf_pkg;

  typedef enum logic {
    UPD_ADD = 1'b0,
    UPD_DEL = 1'b1
  } upd_op_e;

  localparam int NUM_TABLES = 2;

endpackage

// File: rtl/slf_hash.sv
module slf_hash #(
  parameter int ADDR_W = 30,
  parameter int IDX_W  = 10,
  parameter int SEL    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int LO_BASE = 0;
  localparam int HI_BASE = (SEL == 0) ? IDX_W : 2 * IDX_W;

  // Each table folds the low slice with a different upper slice.
  always_comb begin
    idx = addr[LO_BASE +: IDX_W] ^ addr[HI_BASE +: IDX_W];
  end

endmodule

// File: rtl/slf_clear_seq.sv
module slf_clear_seq #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      idx <= idx + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  // R9: the sweep keeps going until the last entry is written
  a_r9_sweep_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != LAST_IDX) |=> busy);

  // R9: the sweep ends right after the last entry
  a_r9_sweep_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == LAST_IDX) |=> !busy);

endmodule

// File: rtl/slf_count_bank.sv
module slf_count_bank
  import slf_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  upd_op_e          upd_op,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic [CNT_W-1:0] look_cnt,
  output logic             upd_was_zero
);

  localparam int               DEPTH   = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] new_cnt;

  always_comb begin
    cur_cnt = mem[upd_idx];
    new_cnt = cur_cnt;
    if (upd_op == UPD_DEL) begin
      if (cur_cnt != '0) new_cnt = cur_cnt - 1'b1;
    end else begin
      if (cur_cnt != CNT_MAX) new_cnt = cur_cnt + 1'b1;
    end
    upd_was_zero = (cur_cnt == '0);
  end

  // Single write port; the clear sweep and updates never overlap.
  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_idx] <= '0;
    end else if (upd_en) begin
      mem[upd_idx] <= new_cnt;
    end
  end

  // Lookup sees an update landing on the same entry in the same cycle.
  always_comb begin
    if (upd_en && !clr_en && (upd_idx == look_idx)) look_cnt = new_cnt;
    else                                            look_cnt = mem[look_idx];
  end

  // R6: a full counter stays full after an insert
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en && upd_op == UPD_ADD && cur_cnt == CNT_MAX)
      |=> mem[$past(upd_idx)] == CNT_MAX);

  // R7: an empty counter stays empty after a remove
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr_en && upd_op == UPD_DEL && cur_cnt == '0)
      |=> mem[$past(upd_idx)] == '0);

  // R9: the sweep writes a zero into each entry it passes
  a_r9_entry_zeroed: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> mem[$past(clr_idx)] == '0);

endmodule

// File: rtl/snoop_line_filter.sv
module snoop_line_filter
  import slf_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int IDX_W  = 10,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_del,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              qry_valid,
  output logic              qry_ready,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              hit_valid,
  output logic              hit_out,
  output logic              underflow_err
);

  logic             clr_busy;
  logic [IDX_W-1:0] clr_idx;
  logic             upd_fire;
  logic             qry_fire;
  upd_op_e          upd_op;

  logic [NUM_TABLES-1:0] cnt_nonzero;
  logic [NUM_TABLES-1:0] was_zero;

  assign upd_ready = !clr_busy;
  assign qry_ready = !clr_busy;
  assign upd_fire  = upd_valid && upd_ready;
  assign qry_fire  = qry_valid && qry_ready;
  assign upd_op    = upd_del ? UPD_DEL : UPD_ADD;

  slf_clear_seq #(.IDX_W(IDX_W)) u_clear (
    .clk   (clk),
    .rst   (rst),
    .start (clr_req),
    .busy  (clr_busy),
    .idx   (clr_idx)
  );

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
    logic [IDX_W-1:0] u_idx;
    logic [IDX_W-1:0] q_idx;
    logic [CNT_W-1:0] q_cnt;

    slf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL(t)) u_hash_upd (
      .addr (upd_addr),
      .idx  (u_idx)
    );

    slf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL(t)) u_hash_qry (
      .addr (qry_addr),
      .idx  (q_idx)
    );

    slf_count_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
      .clk          (clk),
      .rst          (rst),
      .upd_en       (upd_fire),
      .upd_op       (upd_op),
      .upd_idx      (u_idx),
      .clr_en       (clr_busy),
      .clr_idx      (clr_idx),
      .look_idx     (q_idx),
      .look_cnt     (q_cnt),
      .upd_was_zero (was_zero[t])
    );

    assign cnt_nonzero[t] = (q_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit_out   <= 1'b0;
    end else begin
      hit_valid <= qry_fire;
      if (qry_fire) hit_out <= &cnt_nonzero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      underflow_err <= 1'b0;
    end else if (upd_fire && upd_del && (|was_zero)) begin
      underflow_err <= 1'b1;
    end
  end

  // R8: every accepted lookup is answered in the next cycle
  a_r8_answer_next: assert property (@(posedge clk) disable iff (rst)
    qry_fire |=> hit_valid);

  // R8: no answer without an accepted lookup
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !qry_fire |=> !hit_valid);

  // R3: inserting and looking up the same line together always hits
  a_r3_insert_seen: assert property (@(posedge clk) disable iff (rst)
    (qry_fire && upd_fire && !upd_del && upd_addr == qry_addr) |=> hit_out);

  // R7: the error flag never falls outside reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  // R9: a clear request closes both channels on the next cycle
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !clr_busy) |=> (!upd_ready && !qry_ready));

endmodule

// File: tb/snoop_line_filter_bench.sv
`timescale 1ns/1ps
module snoop_line_filter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_req = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_del = 1'b0;
  logic [29:0] upd_addr = '0;
  logic        qry_valid = 1'b0;
  logic [29:0] qry_addr = '0;
  logic        upd_ready, qry_ready, hit_valid, hit_out, underflow_err;

  int checks = 0;
  int fails  = 0;
  int ca [1024];
  int cb [1024];
  bit err_exp = 1'b0;

  always #2.5 clk = ~clk;

  snoop_line_filter u_snoop_line_filter (
    .clk(clk), .rst(rst), .clr_req(clr_req),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_del(upd_del), .upd_addr(upd_addr),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_addr(qry_addr),
    .hit_valid(hit_valid), .hit_out(hit_out), .underflow_err(underflow_err)
  );

  function automatic int ha(logic [29:0] a); return int'(a[9:0] ^ a[19:10]); endfunction
  function automatic int hb(logic [29:0] a); return int'(a[9:0] ^ a[29:20]); endfunction
  function automatic logic [29:0] mk(int s2, int s1, int s0);
    return {s2[9:0], s1[9:0], s0[9:0]};
  endfunction
  function automatic bit model_hit(logic [29:0] a);
    return (ca[ha(a)] != 0) && (cb[hb(a)] != 0);
  endfunction

  task automatic model_upd(bit del, logic [29:0] a);
    int ia = ha(a);
    int ib = hb(a);
    if (del) begin
      if (ca[ia] == 0 || cb[ib] == 0) err_exp = 1'b1;
      if (ca[ia] != 0) ca[ia]--;
      if (cb[ib] != 0) cb[ib]--;
    end else begin
      if (ca[ia] < 1023) ca[ia]++;
      if (cb[ib] < 1023) cb[ib]++;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) begin ca[i] = 0; cb[i] = 0; end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_upd(bit del, logic [29:0] a);
    upd_valid = 1'b1; upd_del = del; upd_addr = a;
    @(negedge clk);
    upd_valid = 1'b0;
    model_upd(del, a);
  endtask

  task automatic do_qry(logic [29:0] a, string tag);
    bit e;
    qry_valid = 1'b1; qry_addr = a;
    @(negedge clk);
    qry_valid = 1'b0;
    e = model_hit(a);
    chk(hit_valid === 1'b1 && hit_out === e, tag, {hit_valid, hit_out}, {1'b1, e});
  endtask

  task automatic do_both(bit del, logic [29:0] ua, logic [29:0] qa, string tag);
    bit e;
    upd_valid = 1'b1; upd_del = del; upd_addr = ua;
    qry_valid = 1'b1; qry_addr = qa;
    @(negedge clk);
    upd_valid = 1'b0; qry_valid = 1'b0;
    model_upd(del, ua);
    e = model_hit(qa);
    chk(hit_valid === 1'b1 && hit_out === e, tag, {hit_valid, hit_out}, {1'b1, e});
  endtask

  task automatic count_busy(string tag);
    int n = 0;
    chk(upd_ready === 1'b0 && qry_ready === 1'b0, tag, upd_ready, 0);
    while (!upd_ready && n < 5000) begin @(negedge clk); n++; end
    chk(n == 1024, tag, n, 1024);
  endtask

  task automatic check_err(string tag);
    chk(underflow_err === err_exp, tag, underflow_err, err_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [29:0] p, q, r, s, z;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset sweep length, then an empty filter
    count_busy("R1 reset sweep");
    check_err("R1 err after reset");
    for (int i = 0; i < 16; i++) do_qry(mk(i * 37, i * 11, i * 5), "R1 empty miss");

    // R2 / R4: chosen slice values give collisions in a single table or in both
    p = mk(0, 5, 3);  // A=6 B=3
    q = mk(7, 1, 2);  // A=3 B=5
    r = mk(5, 6, 0);  // A=6 B=5
    s = mk(9, 6, 0);  // A=6 B=9
    do_upd(1'b0, p);
    do_upd(1'b0, q);
    do_qry(p, "R3 inserted hit");
    do_qry(q, "R3 inserted hit");
    do_qry(r, "R2 R4 false positive from both tables");
    chk(model_hit(r) == 1'b1, "R4 model expects hit", model_hit(r), 1);
    do_qry(s, "R4 only one table set");
    chk(model_hit(s) == 1'b0, "R4 model expects miss", model_hit(s), 0);

    // R5: counting, removal of one of two copies
    do_upd(1'b0, p);
    do_upd(1'b1, p);
    do_qry(p, "R5 one copy left");
    do_upd(1'b1, p);
    do_qry(p, "R5 all copies removed");
    do_qry(r, "R5 collision gone after remove");

    // R8: same-cycle update and lookup of the same line
    do_both(1'b0, mk(100, 200, 300), mk(100, 200, 300), "R8 insert forwarded");
    do_both(1'b1, mk(100, 200, 300), mk(100, 200, 300), "R8 remove forwarded");
    chk(model_hit(mk(100, 200, 300)) == 1'b0, "R8 model miss", 1, 0);
    // R10: independent channels on unrelated lines
    do_both(1'b0, mk(11, 22, 33), q, "R10 parallel lookup");
    do_qry(mk(11, 22, 33), "R10 parallel insert landed");
    @(negedge clk);
    chk(hit_valid === 1'b0, "R8 no extra answer", hit_valid, 0);

    // Sweep: many inserts, some removals, broad lookups against the model
    for (int i = 0; i < 300; i++) do_upd(1'b0, 30'(i * 32'h2545F491 + 17));
    for (int i = 0; i < 300; i += 3) do_upd(1'b1, 30'(i * 32'h2545F491 + 17));
    for (int i = 0; i < 300; i++) do_qry(30'(i * 32'h2545F491 + 17), "R3 R5 sweep member");
    for (int i = 0; i < 300; i++) do_qry(30'(i * 32'h6C8E9CF5 + 5), "R4 sweep other");
    check_err("R5 no error in sweep");

    // R9: clear with an insert in the request cycle
    clr_req = 1'b1;
    do_upd(1'b0, mk(1, 2, 3));
    clr_req = 1'b0;
    count_busy("R9 clear sweep");
    model_clear();
    for (int i = 0; i < 60; i++) do_qry(30'(i * 32'h2545F491 + 17), "R9 miss after clear");
    do_qry(mk(1, 2, 3), "R9 same-cycle insert cleared");
    check_err("R9 err untouched");

    // R6: saturation
    z = mk(900, 800, 700);
    for (int i = 0; i < 1025; i++) do_upd(1'b0, z);
    for (int i = 0; i < 1022; i++) do_upd(1'b1, z);
    do_qry(z, "R6 still present after 1022 removes");
    chk(model_hit(z) == 1'b1, "R6 model present", 0, 1);
    do_upd(1'b1, z);
    do_qry(z, "R6 gone after 1023 removes");
    check_err("R6 no error at saturation");

    // R7: remove with a zero counter in table B only
    p = mk(1, 2, 3);  // A=1 B=2
    q = mk(4, 0, 1);  // A=1 B=5
    do_upd(1'b0, p);
    do_qry(p, "R7 setup hit");
    check_err("R7 err low before");
    do_upd(1'b1, q);
    check_err("R7 err raised");
    chk(underflow_err === 1'b1, "R7 err set", underflow_err, 1);
    do_qry(p, "R7 shared counter decremented");
    do_upd(1'b0, p);
    do_qry(p, "R7 later insert");
    check_err("R7 err sticky");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule